// File: doc/BRIEF.md
# Load/Store Multiple Address Sequencer

This block drives the memory side of a single block-transfer instruction that moves several 32-bit registers to or from memory. A one-cycle `start` pulse captures a base address, a 16-bit mask that selects registers, a direction (load or store), an address ordering (increment-after or decrement-before) and a writeback enable. The block then issues one word request per selected register on a valid/ready interface. Each request carries a word address, the register index and a write flag. It returns the final base value so that the base register can be written back.

Registers always go out in ascending index order, and the lowest-numbered register sits at the lowest address. In decrement-before mode the block first lowers the base by four bytes per selected register and then walks upward. A push is therefore a decrement-before store with writeback, and a pop is an increment-after load with writeback. A load into the highest register index (the program counter) is reported so that the core can branch. If bit 0 of that loaded word is 0, a fault flag is raised, because bit 0 must be 1 to mark the state the core runs in.

Top module: `lsm_seq`

## Requirements
- R1: In increment-after mode (`dec_before`=0), the first request address equals the base, and each later request address is 4 higher than the one before it.
- R2: In decrement-before mode (`dec_before`=1), the first request address equals base − 4·N, where N is the number of set bits in the mask, and each later request address is 4 higher.
- R3: Requests name the registers whose mask bit is set, in strictly ascending index order, and skip every clear bit. Mask bit i selects register index i.
- R4: While `req_valid` is high and `req_ready` is low, `req_addr`, `req_reg` and `req_write` hold their values into the next cycle.
- R5: With writeback enabled, `done` and `wb_we` pulse high for one cycle, one cycle after the final handshake. During that cycle `wb_value` equals base + 4·N (increment-after) or base − 4·N (decrement-before), computed modulo 2^32.
- R6: With writeback disabled, `wb_we` stays low, and `wb_value` equals the unchanged base during the `done` cycle.
- R7: `req_write` is 1 for a store (`is_load`=0) and 0 for a load (`is_load`=1).
- R8: With an all-zero mask, `done` pulses one cycle after `start`, `busy` and `req_valid` stay low, and `wb_value` equals the base.
- R9: `busy` (which equals `req_valid`) rises one cycle after an accepted start with a non-empty mask and falls one cycle after the last handshake. A `start` pulse that arrives while busy changes nothing and starts no further transfer.
- R10: One cycle after a load handshake on register index 15, `pc_load` pulses. `pc_fault` pulses with it if `ld_data_lsb` (bit 0 of the loaded word) was 0 on that handshake.
- R11: During and right after reset, `busy`, `req_valid`, `done`, `wb_we`, `pc_load` and `pc_fault` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; accepted only while idle |
| base_addr | input | 32 | Base address of the transfer |
| reg_mask | input | 16 | Register select mask; bit i selects register i |
| is_load | input | 1 | 1 = memory to registers, 0 = registers to memory |
| dec_before | input | 1 | 1 = decrement-before, 0 = increment-after |
| wb_en | input | 1 | Write the final address back to the base register |
| req_valid | output | 1 | Memory request present |
| req_ready | input | 1 | Memory accepts the request this cycle |
| req_addr | output | 32 | Word address of the request |
| req_reg | output | 4 | Register index of the request |
| req_write | output | 1 | 1 = store request, 0 = load request |
| ld_data_lsb | input | 1 | Bit 0 of the loaded word, valid on a load handshake |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| wb_we | output | 1 | Base writeback strobe, high with `done` when writeback is on |
| wb_value | output | 32 | Final base value, valid during `done` |
| pc_load | output | 1 | A load into register 15 completed |
| pc_fault | output | 1 | That load carried a clear bit 0 |

## Verification
Every output is registered, so the first request appears exactly one cycle after `start`. Each next request appears one cycle after the handshake that retired the previous one, and `done`, `wb_we` and `pc_load` come one cycle after the handshake that triggers them. The bench changes inputs and samples outputs 1 time unit after each rising edge, and it compares against the value due at that edge. It computes expected addresses and register indices from the mask itself, and after a stalled cycle it compares against the held request. After each transfer it spends one extra cycle confirming that `done` has fallen and that no second transfer began.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

   typedef enum logic {
      ORD_INC_AFTER  = 1'b0,
      ORD_DEC_BEFORE = 1'b1
   } lsm_order_e;

   typedef enum logic {
      DIR_STORE = 1'b0,
      DIR_LOAD  = 1'b1
   } lsm_dir_e;

   function automatic int unsigned lsm_log2(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction

endpackage

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
   parameter int NREG  = 16,
   parameter int CNT_W = $clog2(NREG + 1)
) (
   input  logic [NREG-1:0]  mask,
   output logic [CNT_W-1:0] count
);
   always_comb begin
      count = '0;
      for (int i = 0; i < NREG; i++) begin
         count = count + CNT_W'(mask[i]);
      end
   end
endmodule

// File: rtl/lsm_lowest.sv
module lsm_lowest #(
   parameter int NREG  = 16,
   parameter int IDX_W = $clog2(NREG)
) (
   input  logic [NREG-1:0]  mask,
   output logic [IDX_W-1:0] low_idx,
   output logic [NREG-1:0]  rest
);
   logic [NREG:0]   below_clear;
   logic [NREG-1:0] pick;

   assign below_clear[0] = 1'b1;

   for (genvar i = 0; i < NREG; i++) begin : g_chain
      assign pick[i]          = mask[i] & below_clear[i];
      assign below_clear[i+1] = below_clear[i] & ~mask[i];
   end

   always_comb begin
      low_idx = '0;
      for (int i = 0; i < NREG; i++) begin
         if (pick[i]) low_idx = low_idx | IDX_W'(i);
      end
   end

   assign rest = mask & ~pick;
endmodule

// File: rtl/lsm_addr_calc.sv
module lsm_addr_calc #(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 5,
   parameter int WORD_BYTES = 4
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [CNT_W-1:0]  count,
   input  logic              dec_before,
   output logic [ADDR_W-1:0] first_addr,
   output logic [ADDR_W-1:0] final_addr
);
   localparam int SH = $clog2(WORD_BYTES);

   logic [ADDR_W-1:0] span;
   logic [ADDR_W-1:0] lowered;

   assign span    = ADDR_W'(count) << SH;
   assign lowered = base - span;

   assign first_addr = dec_before ? lowered : base;
   assign final_addr = dec_before ? lowered : (base + span);
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq #(
   parameter int ADDR_W     = 32,
   parameter int NREG       = 16,
   parameter int WORD_BYTES = 4,
   parameter int IDX_W      = $clog2(NREG),
   parameter int CNT_W      = $clog2(NREG + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [NREG-1:0]   reg_mask,
   input  logic              is_load,
   input  logic              dec_before,
   input  logic              wb_en,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr,
   output logic [IDX_W-1:0]  req_reg,
   output logic              req_write,
   input  logic              ld_data_lsb,
   output logic              busy,
   output logic              done,
   output logic              wb_we,
   output logic [ADDR_W-1:0] wb_value,
   output logic              pc_load,
   output logic              pc_fault
);
   import lsm_pkg::*;

   localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(WORD_BYTES);
   localparam logic [IDX_W-1:0]  PC_IDX  = IDX_W'(NREG - 1);

   if (WORD_BYTES != (1 << lsm_log2(WORD_BYTES))) begin : g_chk_word
      $error("WORD_BYTES must be a power of two");
   end
   if (NREG < 2) begin : g_chk_nreg
      $error("NREG must be at least 2");
   end
   if (ADDR_W <= CNT_W + lsm_log2(WORD_BYTES)) begin : g_chk_addr
      $error("ADDR_W too narrow for the largest transfer span");
   end

   logic              busy_q;
   logic [NREG-1:0]   mask_q;
   logic [ADDR_W-1:0] addr_q;
   lsm_dir_e          dir_q;
   logic              wb_en_q;
   logic [ADDR_W-1:0] wb_val_q;
   logic              done_q, wb_we_q, pc_load_q, pc_fault_q;

   logic [CNT_W-1:0]  in_count;
   logic [ADDR_W-1:0] in_first, in_final;
   logic [IDX_W-1:0]  cur_idx;
   logic [NREG-1:0]   cur_rest;
   logic              in_empty, hs, hs_last, hs_pc;
   lsm_order_e        in_order;

   assign in_order = dec_before ? ORD_DEC_BEFORE : ORD_INC_AFTER;

   lsm_popcnt #(.NREG(NREG), .CNT_W(CNT_W)) u_cnt (
      .mask  (reg_mask),
      .count (in_count)
   );

   lsm_addr_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) u_addr (
      .base       (base_addr),
      .count      (in_count),
      .dec_before (in_order == ORD_DEC_BEFORE),
      .first_addr (in_first),
      .final_addr (in_final)
   );

   lsm_lowest #(.NREG(NREG), .IDX_W(IDX_W)) u_low (
      .mask    (mask_q),
      .low_idx (cur_idx),
      .rest    (cur_rest)
   );

   assign in_empty = (in_count == '0);
   assign hs       = busy_q & req_ready;
   assign hs_last  = hs & (cur_rest == '0);
   assign hs_pc    = hs & (dir_q == DIR_LOAD) & (cur_idx == PC_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         mask_q     <= '0;
         addr_q     <= '0;
         dir_q      <= DIR_STORE;
         wb_en_q    <= 1'b0;
         wb_val_q   <= '0;
         done_q     <= 1'b0;
         wb_we_q    <= 1'b0;
         pc_load_q  <= 1'b0;
         pc_fault_q <= 1'b0;
      end else begin
         done_q     <= 1'b0;
         wb_we_q    <= 1'b0;
         pc_load_q  <= hs_pc;
         pc_fault_q <= hs_pc & ~ld_data_lsb;
         if (!busy_q) begin
            if (start) begin
               dir_q    <= is_load ? DIR_LOAD : DIR_STORE;
               wb_en_q  <= wb_en;
               wb_val_q <= wb_en ? in_final : base_addr;
               if (in_empty) begin
                  done_q  <= 1'b1;
                  wb_we_q <= wb_en;
               end else begin
                  busy_q <= 1'b1;
                  mask_q <= reg_mask;
                  addr_q <= in_first;
               end
            end
         end else if (hs) begin
            mask_q <= cur_rest;
            addr_q <= addr_q + STEP;
            if (hs_last) begin
               busy_q  <= 1'b0;
               done_q  <= 1'b1;
               wb_we_q <= wb_en_q;
            end
         end
      end
   end

   assign busy      = busy_q;
   assign req_valid = busy_q;
   assign req_addr  = addr_q;
   assign req_reg   = cur_idx;
   assign req_write = (dir_q == DIR_STORE);
   assign done      = done_q;
   assign wb_we     = wb_we_q;
   assign wb_value  = wb_val_q;
   assign pc_load   = pc_load_q;
   assign pc_fault  = pc_fault_q;
endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
   parameter int ADDR_W     = 32,
   parameter int NREG       = 16,
   parameter int WORD_BYTES = 4,
   parameter int IDX_W      = $clog2(NREG)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [NREG-1:0]   reg_mask,
   input logic              busy,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic [IDX_W-1:0]  req_reg,
   input logic              req_write,
   input logic              done,
   input logic              wb_we,
   input logic              pc_load,
   input logic              pc_fault
);
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!req_valid || req_addr == $past(req_addr) + ADDR_W'(WORD_BYTES))); // R1
   AST_REG_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!req_valid || req_reg > $past(req_reg))); // R3
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_reg) && $stable(req_write))); // R4
   AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_we |-> done); // R5
   AST_EMPTY_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && reg_mask == '0) |=> (done && !req_valid)); // R8
   AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && reg_mask != '0) |=> busy); // R9
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R9
   AST_FAULT_PC: assert property (@(posedge clk) disable iff (!rst_n)
      pc_fault |-> pc_load); // R10
endmodule

bind lsm_seq lsm_seq_chk #(
   .ADDR_W(ADDR_W), .NREG(NREG), .WORD_BYTES(WORD_BYTES), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .reg_mask(reg_mask), .busy(busy),
   .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
   .req_reg(req_reg), .req_write(req_write), .done(done), .wb_we(wb_we),
   .pc_load(pc_load), .pc_fault(pc_fault)
);

// File: tb/lsm_seq_test.sv
module lsm_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 7;

   // {base[32], mask[16], load, dec, wb, odd_lsb, stall, final[32]}
   localparam logic [84:0] VEC [NV] = '{
      {32'h0000_8000, 16'h000F, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_8010},
      {32'h2000_1000, 16'h40F0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h2000_0FEC},
      {32'h2000_0FEC, 16'h80F0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 32'h2000_1000},
      {32'h0000_0100, 16'h8001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0100},
      {32'h0000_4000, 16'hFFFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_3FC0},
      {32'h0000_0010, 16'h0400, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_000C},
      {32'hFFFF_FFF8, 16'h0003, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] base_addr = '0;
   logic [15:0] reg_mask = '0;
   logic        is_load = 1'b0, dec_before = 1'b0, wb_en = 1'b0;
   logic        req_ready = 1'b0, ld_data_lsb = 1'b0;
   logic        req_valid, req_write, busy, done, wb_we, pc_load, pc_fault;
   logic [31:0] req_addr, wb_value;
   logic [3:0]  req_reg;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lsm_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
      .reg_mask(reg_mask), .is_load(is_load), .dec_before(dec_before),
      .wb_en(wb_en), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_reg(req_reg), .req_write(req_write),
      .ld_data_lsb(ld_data_lsb), .busy(busy), .done(done), .wb_we(wb_we),
      .wb_value(wb_value), .pc_load(pc_load), .pc_fault(pc_fault)
   );

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic run_op(input logic [84:0] v, input bit inject);
      logic [31:0] base, expf, first, held_addr;
      logic [15:0] mask;
      logic        ld, dec, wb, odd, stall, rdy, pend_pc, exp_fault, prev_stall;
      int          idx[16];
      int          n, k, cyc;
      logic [3:0]  held_reg;
      base = v[84:53]; mask = v[52:37]; ld = v[36]; dec = v[35];
      wb = v[34]; odd = v[33]; stall = v[32]; expf = v[31:0];
      n = 0;
      for (int i = 0; i < 16; i++) if (mask[i]) begin idx[n] = i; n++; end
      first = dec ? base - 32'(4 * n) : base;
      base_addr = base; reg_mask = mask; is_load = ld; dec_before = dec;
      wb_en = wb; start = 1'b1;
      tick();
      start = 1'b0;
      k = 0; cyc = 0; pend_pc = 1'b0; exp_fault = 1'b0; prev_stall = 1'b0;
      held_addr = '0; held_reg = '0;
      if (n == 0) begin
         check(done === 1'b1, "R8", "done after empty start", 32'(done), 1);
         check(busy === 1'b0 && req_valid === 1'b0, "R8", "no request on empty mask",
               32'({busy, req_valid}), 0);
         check(wb_value === base, "R8", "empty wb_value", wb_value, base);
      end
      while (k < n && cyc < 400) begin
         if (pend_pc) begin
            check(pc_load === 1'b1, "R10", "pc_load pulse", 32'(pc_load), 1);
            check(pc_fault === exp_fault, "R10", "pc_fault", 32'(pc_fault), 32'(exp_fault));
            pend_pc = 1'b0;
         end
         check(busy === 1'b1 && req_valid === 1'b1, "R9", "busy/valid during transfer",
               32'({busy, req_valid}), 3);
         if (prev_stall) begin
            check(req_addr === held_addr && req_reg === held_reg, "R4", "request held in stall",
                  req_addr, held_addr);
         end
         check(req_addr === first + 32'(4 * k), dec ? "R2" : "R1", "request address",
               req_addr, first + 32'(4 * k));
         check(req_reg === 4'(idx[k]), "R3", "register index", 32'(req_reg), 32'(idx[k]));
         check(req_write === ~ld, "R7", "write flag", 32'(req_write), 32'(~ld));
         if (inject && cyc == 0) begin
            start = 1'b1; reg_mask = 16'h0001; base_addr = 32'h0;
         end else begin
            start = 1'b0;
         end
         rdy = !(stall && cyc[0] == 1'b0);
         req_ready = rdy;
         ld_data_lsb = odd;
         if (rdy && ld && idx[k] == 15) begin
            pend_pc = 1'b1; exp_fault = !odd;
         end
         prev_stall = !rdy; held_addr = req_addr; held_reg = req_reg;
         tick();
         if (rdy) k++;
         cyc++;
      end
      req_ready = 1'b0; start = 1'b0;
      if (n != 0) begin
         if (pend_pc) begin
            check(pc_load === 1'b1, "R10", "pc_load pulse", 32'(pc_load), 1);
            check(pc_fault === exp_fault, "R10", "pc_fault", 32'(pc_fault), 32'(exp_fault));
         end
         check(done === 1'b1 && busy === 1'b0 && req_valid === 1'b0, "R9",
               "done and idle after last handshake", 32'({done, busy, req_valid}), 3'b100);
         check(wb_value === expf, wb ? "R5" : "R6", "wb_value", wb_value, expf);
      end
      check(wb_we === wb, wb ? "R5" : "R6", "wb_we", 32'(wb_we), 32'(wb));
      tick();
      check(done === 1'b0 && req_valid === 1'b0, "R9", "no second transfer",
            32'({done, req_valid}), 0);
   endtask

   initial begin
      repeat (3) tick();
      check(busy === 1'b0 && req_valid === 1'b0 && done === 1'b0, "R11", "reset idle",
            32'({busy, req_valid, done}), 0);
      check(wb_we === 1'b0 && pc_load === 1'b0 && pc_fault === 1'b0, "R11", "reset flags",
            32'({wb_we, pc_load, pc_fault}), 0);
      rst_n = 1'b1;
      tick();
      for (int t = 0; t < NV; t++) run_op(VEC[t], 1'b0);
      // R9: start pulses while busy are ignored
      run_op({32'h0000_2000, 16'h0824, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_200C}, 1'b1);
      // R8: empty mask, writeback on and off
      run_op({32'h0000_3000, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_3000}, 1'b0);
      run_op({32'h0000_5000, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_5000}, 1'b0);
      // R11: reset in the middle of a transfer
      base_addr = 32'h40; reg_mask = 16'h00FF; is_load = 1'b0; dec_before = 1'b0;
      wb_en = 1'b1; start = 1'b1;
      tick();
      start = 1'b0; rst_n = 1'b0;
      tick();
      check(busy === 1'b0 && req_valid === 1'b0 && done === 1'b0 && wb_we === 1'b0,
            "R11", "reset aborts transfer", 32'({busy, req_valid, done, wb_we}), 0);
      rst_n = 1'b1;
      tick();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule